// File: doc/BRIEF.md
# Cycle-Stealing Counter Increment Unit

This unit keeps a set of hardware counters in ordinary working memory rather than in dedicated registers. Each counter has a fixed word address. External events arrive as single-cycle pulses on per-counter request lines, and each pulse carries a two-bit operation code. A pulse is latched and waits until the processor reaches the end of a memory cycle, which it reports with a boundary strobe.

At a boundary with at least one request waiting, the unit stalls the processor and takes the memory port. For each waiting counter, lowest index first, it spends one cycle reading the word and one cycle writing back the updated word. It keeps going until no request is left. Only then does it drop the stall so that normal execution resumes. If nothing is waiting at the boundary, the processor simply continues and no cycle is lost.

Counters are 15-bit one's-complement words. An increment past the largest positive value or a decrement past the most negative value is an overflow. Under per-stage enable bits, that overflow can raise a request on the next counter up.

Top module: `ctr_steal_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `stall`, `mem_en` and `mem_we` are low and no request is pending.
- R2: A request pulse is latched and held for as long as no boundary strobe arrives; in that time `stall` stays low and memory is not touched.
- R3: The pending check happens only in a cycle where `cyc_end` is high and the unit is idle. If a request is pending, `stall` goes high on the next cycle. If none is pending, `stall` stays low and no cycle is stolen.
- R4: Each service is a read cycle (`mem_en`=1, `mem_we`=0) at address `CTR_BASE`+index. It is followed directly by a write cycle to the same address. `stall` is high in both cycles.
- R5: The operation code selects the update: 2'b00 adds one, 2'b01 subtracts one, 2'b10 shifts left by one and enters 0 at bit 0, and 2'b11 shifts left by one and enters 1 at bit 0. For the shifts, bit 14 is discarded and no overflow is raised.
- R6: Arithmetic is one's-complement. Adding one to minus zero (15'h7FFF) gives +1, and adding one to -1 (15'h7FFE) gives minus zero. Subtracting one from plus zero gives -1 (15'h7FFE), and subtracting one from +1 gives plus zero.
- R7: Adding one to 15'h3FFF writes 15'h0000, and subtracting one from 15'h4000 writes 15'h7FFF. Both are overflows. If `chain_en[i]` is set, an overflow of counter i raises a request on counter i+1 in the same direction. If the bit is clear, counter i+1 is left alone.
- R8: When several requests are pending, the lowest-indexed counter is serviced first.
- R9: All pending requests, including ones that arrive or are chained during the drain, are serviced back to back. `stall` falls in the cycle after the last write.
- R10: A pulse on a line during the write cycle of that same line's service is kept. That counter is then serviced again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pulse | input | NUM_CTR | One pulse per counter event |
| req_op | input | 2*NUM_CTR | Operation code per line, bits [2i+1:2i] for line i, sampled with its pulse |
| chain_en | input | NUM_CTR-1 | Bit i routes counter i's overflow to counter i+1 |
| cyc_end | input | 1 | Processor memory-cycle boundary strobe |
| stall | output | 1 | High in every stolen cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write enable (read when low) |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The first read of a drain appears in the cycle right after the boundary strobe. Its write follows one cycle later, once the synchronous memory returns the data. The next read, or the drop of `stall`, comes in the cycle after that write. A pulse takes effect at the edge that samples it, so a pulse during a write cycle decides whether the drain goes on. The bench keeps a behavioural model that advances at each rising edge and compares `stall`, the memory strobes, the address and the write data at every falling edge. Directed checks then read the memory words, the order of reads and the stall length after each drain.

// File: rtl/ctr_steal_pkg.sv
// Shared types for the cycle-stealing counter unit.
// Assumes a two-bit operation code per request line.
package ctr_steal_pkg;

    typedef enum logic [1:0] {
        OP_INC  = 2'b00,
        OP_DEC  = 2'b01,
        OP_SHL0 = 2'b10,
        OP_SHL1 = 2'b11
    } ctr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } steal_st_e;

endpackage

// File: rtl/ctr_req_latch.sv
// Holds one counter's pending request and the operation code that goes with it.
// An external pulse takes priority over a chained overflow request and over a clear.
// Assumes clr is only asserted in the write cycle of this line's service.
module ctr_req_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse,
    input  logic [1:0] pulse_op,
    input  logic       chain_set,
    input  logic [1:0] chain_op,
    input  logic       clr,
    output logic       pend_q,
    output logic       pend_d,
    output logic [1:0] op_q
);

    logic [1:0] op_d;

    // Next pending state: set by pulse or chain, dropped by the service write.
    always_comb begin
        pend_d = pulse | chain_set | (pend_q & ~clr);
        if (pulse)          op_d = pulse_op;
        else if (chain_set) op_d = chain_op;
        else                op_d = op_q;
    end

    // Register the pending flag and its operation code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            op_q   <= 2'b00;
        end else begin
            pend_q <= pend_d;
            op_q   <= op_d;
        end
    end

    a_r10_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> pend_q);

    a_r2_held_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/ctr_low_first.sv
// Fixed-priority picker: returns the index of the lowest set request bit.
// Assumes NUM_REQ >= 2 and IDX_W wide enough for NUM_REQ-1.
module ctr_low_first #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/ctr_word_update.sv
// Computes the new counter word for one service cycle.
// Words are one's-complement; overflow is flagged only on add/subtract past range.
module ctr_word_update
    import ctr_steal_pkg::*;
#(
    parameter int DATA_W = 15
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ovf,
    output logic              ovf_up
);

    localparam logic [DATA_W-1:0] POS_ZERO = '0;
    localparam logic [DATA_W-1:0] NEG_ZERO = '1;
    localparam logic [DATA_W-1:0] POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    ctr_op_e op_e;

    // Apply the selected operation with one's-complement zero handling.
    always_comb begin
        op_e   = ctr_op_e'(op);
        ovf    = 1'b0;
        ovf_up = (op_e == OP_INC);
        unique case (op_e)
            OP_INC: begin
                if (din == POS_MAX) begin
                    dout = POS_ZERO;
                    ovf  = 1'b1;
                end else if (din == NEG_ZERO) begin
                    dout = ONE;
                end else begin
                    dout = din + ONE;
                end
            end
            OP_DEC: begin
                if (din == NEG_MIN) begin
                    dout = NEG_ZERO;
                    ovf  = 1'b1;
                end else if (din == POS_ZERO) begin
                    dout = NEG_ZERO - ONE;
                end else begin
                    dout = din - ONE;
                end
            end
            OP_SHL0: dout = {din[DATA_W-2:0], 1'b0};
            default: dout = {din[DATA_W-2:0], 1'b1};
        endcase
    end

endmodule

// File: rtl/ctr_steal_unit.sv
// Top of the cycle-stealing counter unit. At an idle memory-cycle boundary with
// requests pending, it stalls the processor and does read/write service pairs,
// lowest index first, until no request remains.
// Assumes a synchronous memory with one cycle of read latency and NUM_CTR >= 2.
module ctr_steal_unit
    import ctr_steal_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int DATA_W   = 15,
    parameter int ADDR_W   = 6,
    parameter int CTR_BASE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CTR-1:0]     req_pulse,
    input  logic [2*NUM_CTR-1:0]   req_op,
    input  logic [NUM_CTR-2:0]     chain_en,
    input  logic                   cyc_end,
    output logic                   stall,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata
);

    localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CTR_BASE);

    steal_st_e            st_q, st_d;
    logic [IDX_W-1:0]     sel_q, sel_d;
    logic                 in_write;
    logic [NUM_CTR-1:0]   pend_q, pend_d, clr_vec, chain_vec, pick_vec;
    logic [2*NUM_CTR-1:0] op_flat;
    logic [1:0]           sel_op, chain_op;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_any;
    logic [DATA_W-1:0]    upd_dout;
    logic                 upd_ovf, upd_up;

    assign in_write = (st_q == ST_WRITE);
    assign chain_op = upd_up ? OP_INC : OP_DEC;
    assign sel_op   = op_flat[{sel_q, 1'b0} +: 2];

    // Per-line request latches, clear lines and overflow chaining.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_line
        assign clr_vec[i] = in_write && (sel_q == IDX_W'(i));
        if (i == 0) begin : g_head
            assign chain_vec[i] = 1'b0;
        end else begin : g_link
            assign chain_vec[i] = in_write && (sel_q == IDX_W'(i - 1))
                                  && upd_ovf && chain_en[i-1];
        end
        ctr_req_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse     (req_pulse[i]),
            .pulse_op  (req_op[2*i +: 2]),
            .chain_set (chain_vec[i]),
            .chain_op  (chain_op),
            .clr       (clr_vec[i]),
            .pend_q    (pend_q[i]),
            .pend_d    (pend_d[i]),
            .op_q      (op_flat[2*i +: 2])
        );
    end

    // In a write cycle, look ahead at the post-edge pending set so the drain
    // goes on without a gap.
    assign pick_vec = in_write ? pend_d : pend_q;

    ctr_low_first #(
        .NUM_REQ (NUM_CTR),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req (pick_vec),
        .idx (pick_idx),
        .any (pick_any)
    );

    ctr_word_update #(
        .DATA_W (DATA_W)
    ) u_upd (
        .op     (sel_op),
        .din    (mem_rdata),
        .dout   (upd_dout),
        .ovf    (upd_ovf),
        .ovf_up (upd_up)
    );

    // Next-state logic for the steal sequencer.
    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cyc_end && pick_any) begin
                    st_d  = ST_READ;
                    sel_d = pick_idx;
                end
            end
            ST_READ: st_d = ST_WRITE;
            ST_WRITE: begin
                if (pick_any) begin
                    st_d  = ST_READ;
                    sel_d = pick_idx;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and selected-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sel_q <= '0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    // Memory port and stall outputs.
    always_comb begin
        stall     = (st_q != ST_IDLE);
        mem_en    = stall;
        mem_we    = in_write;
        mem_addr  = BASE_A + {{(ADDR_W-IDX_W){1'b0}}, sel_q};
        mem_wdata = upd_dout;
    end

    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we && $stable(mem_addr)));

    a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_en && !mem_we));

    a_r3_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(cyc_end));

    a_r9_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && |(pend_q & ~clr_vec)) |=> stall);

    a_r9_release_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (pend_q == '0));

    a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> (pick_vec[pick_idx] &&
                      ((pick_vec & ((NUM_CTR'(1) << pick_idx) - NUM_CTR'(1))) == '0)));

endmodule

// File: tb/ctr_steal_unit_tb.sv
module ctr_steal_unit_tb;

    localparam int N    = 4;
    localparam int DW   = 15;
    localparam int AW   = 6;
    localparam int BASE = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    req_pulse;
    logic [2*N-1:0]  req_op;
    logic [N-2:0]    chain_en;
    logic            cyc_end;
    logic            stall, mem_en, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata, mem_rdata;

    ctr_steal_unit #(.NUM_CTR(N), .DATA_W(DW), .ADDR_W(AW), .CTR_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_op(req_op),
        .chain_en(chain_en), .cyc_end(cyc_end), .stall(stall), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Synchronous working memory.
    logic [DW-1:0] ram    [0:(1<<AW)-1];
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    logic [DW-1:0] rdata_q;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        rdata_q <= ram[mem_addr];
        end
    end
    assign mem_rdata = rdata_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Expected update from the requirement text: returns {overflow, word}.
    function automatic logic [DW:0] expect_word(input int op, input logic [DW-1:0] v);
        case (op)
            0: begin
                if (v == 15'h3FFF) return {1'b1, 15'h0000};
                if (v == 15'h7FFF) return {1'b0, 15'h0001};
                return {1'b0, 15'(v + 1)};
            end
            1: begin
                if (v == 15'h4000) return {1'b1, 15'h7FFF};
                if (v == 15'h0000) return {1'b0, 15'h7FFE};
                return {1'b0, 15'(v - 1)};
            end
            2: return {1'b0, v[13:0], 1'b0};
            default: return {1'b0, v[13:0], 1'b1};
        endcase
    endfunction

    function automatic int lowest(input bit [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return 0;
    endfunction

    // Behavioural reference: phase 0 idle, 1 read, 2 write.
    int       m_phase = 0;
    int       m_sel   = 0;
    bit [N-1:0] m_pend = '0;
    int       m_op [N];

    always @(posedge clk) begin
        int old_phase;
        bit [N-1:0] old_pend;
        logic [DW:0] r;
        if (!rst_n) begin
            m_phase = 0; m_sel = 0; m_pend = '0;
            for (int i = 0; i < N; i++) m_op[i] = 0;
        end else begin
            old_phase = m_phase;
            old_pend  = m_pend;
            if (m_phase == 2) begin
                r = expect_word(m_op[m_sel], shadow[BASE + m_sel]);
                shadow[BASE + m_sel] = r[DW-1:0];
                m_pend[m_sel] = 1'b0;
                if (r[DW] && m_sel < N - 1 && chain_en[m_sel]) begin
                    m_pend[m_sel + 1] = 1'b1;
                    m_op[m_sel + 1]   = (m_op[m_sel] == 0) ? 0 : 1;
                end
            end
            for (int i = 0; i < N; i++) begin
                if (req_pulse[i]) begin
                    m_pend[i] = 1'b1;
                    m_op[i]   = int'(req_op[2*i +: 2]);
                end
            end
            if (old_phase == 1) m_phase = 2;
            else if (old_phase == 2) begin
                if (m_pend != '0) begin m_phase = 1; m_sel = lowest(m_pend); end
                else m_phase = 0;
            end else if (cyc_end && old_pend != '0) begin
                m_phase = 1; m_sel = lowest(old_pend);
            end
        end
    end

    // Every-cycle comparison against the model (R4, R9 sequencing).
    always @(negedge clk) begin
        logic [DW:0] r;
        if (rst_n && !done) begin
            chk("R9 stall per cycle", int'(stall), int'(m_phase != 0));
            if (m_phase != 0) begin
                chk("R4 write enable per cycle", int'(mem_we), int'(m_phase == 2));
                chk("R4 address per cycle", int'(mem_addr), BASE + m_sel);
                if (m_phase == 2) begin
                    r = expect_word(m_op[m_sel], shadow[BASE + m_sel]);
                    chk("R5 R6 write data per cycle", int'(mem_wdata), int'(r[DW-1:0]));
                end
            end else begin
                chk("R3 no access while idle", int'(mem_en), 0);
            end
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R9 actual=%0d expected=<20000 cycles", cyc);
            report();
            $finish;
        end
    end

    int stall_cnt;
    int reads [$];

    task automatic preload(input int a, input logic [DW-1:0] v);
        ram[a] = v; shadow[a] = v;
    endtask

    task automatic fire(input int idx, input int op);
        req_pulse[idx] = 1'b1;
        req_op[2*idx +: 2] = 2'(op);
    endtask

    task automatic step_release();
        @(negedge clk);
        req_pulse = '0;
    endtask

    task automatic boundary();
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    task automatic drain();
        stall_cnt = 0;
        reads.delete();
        while (stall && stall_cnt < 100) begin
            stall_cnt++;
            if (mem_en && !mem_we) reads.push_back(int'(mem_addr));
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < (1 << AW); a++) begin ram[a] = '0; shadow[a] = '0; end
        rst_n = 0; req_pulse = '0; req_op = '0; chain_en = '0; cyc_end = 0;
        repeat (3) @(negedge clk);
        chk("R1 stall in reset", int'(stall), 0);
        chk("R1 mem_en in reset", int'(mem_en), 0);
        chk("R1 mem_we in reset", int'(mem_we), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 stall after reset", int'(stall), 0);

        // R3: boundary with nothing pending steals nothing.
        boundary();
        chk("R3 no gap when empty", int'(stall), 0);

        // R2: latched request waits for a boundary.
        preload(BASE, 15'h0005);
        fire(0, 0); step_release();
        for (int k = 0; k < 10; k++) begin
            chk("R2 held without boundary", int'(stall), 0);
            @(negedge clk);
        end
        boundary();
        chk("R3 stall after boundary", int'(stall), 1);
        drain();
        chk("R5 increment result", int'(ram[BASE]), 16'h0006);

        // R6, R8, R9: four pending at once.
        preload(BASE + 0, 15'h4000);
        preload(BASE + 1, 15'h0000);
        preload(BASE + 2, 15'h7FFF);
        preload(BASE + 3, 15'h0001);
        fire(3, 1); fire(2, 0); fire(1, 1); fire(0, 0); step_release();
        boundary();
        drain();
        chk("R8 first read", reads.size() > 0 ? reads[0] : -1, BASE + 0);
        chk("R8 last read", reads.size() > 3 ? reads[3] : -1, BASE + 3);
        chk("R9 drain length", stall_cnt, 8);
        chk("R6 inc of most negative", int'(ram[BASE + 0]), 16'h4001);
        chk("R6 dec of plus zero", int'(ram[BASE + 1]), 16'h7FFE);
        chk("R6 inc of minus zero", int'(ram[BASE + 2]), 16'h0001);
        chk("R6 dec of plus one", int'(ram[BASE + 3]), 16'h0000);

        // R5: shifts.
        preload(BASE + 0, 15'h4001);
        preload(BASE + 1, 15'h1234);
        fire(1, 2); fire(0, 3); step_release();
        boundary();
        drain();
        chk("R5 shift entering one", int'(ram[BASE + 0]), 16'h0003);
        chk("R5 shift entering zero", int'(ram[BASE + 1]), 16'h2468);

        // R7: overflow chaining up and down, and disabled link.
        chain_en = 3'b011;
        preload(BASE + 0, 15'h3FFF);
        preload(BASE + 1, 15'h0010);
        fire(0, 0); step_release();
        boundary();
        drain();
        chk("R7 up overflow wraps", int'(ram[BASE + 0]), 16'h0000);
        chk("R7 up overflow chained", int'(ram[BASE + 1]), 16'h0011);
        chk("R7 chained drain length", stall_cnt, 4);
        preload(BASE + 1, 15'h4000);
        preload(BASE + 2, 15'h0005);
        fire(1, 1); step_release();
        boundary();
        drain();
        chk("R7 down overflow wraps", int'(ram[BASE + 1]), 16'h7FFF);
        chk("R7 down overflow chained", int'(ram[BASE + 2]), 16'h0004);
        chain_en = 3'b000;
        preload(BASE + 2, 15'h3FFF);
        preload(BASE + 3, 15'h0022);
        fire(2, 0); step_release();
        boundary();
        drain();
        chk("R7 overflow without link", int'(ram[BASE + 2]), 16'h0000);
        chk("R7 unlinked neighbour unchanged", int'(ram[BASE + 3]), 16'h0022);
        chk("R7 unlinked drain length", stall_cnt, 2);

        // R10: pulse on the same line during its write cycle.
        preload(BASE, 15'h0100);
        fire(0, 0); step_release();
        boundary();
        for (int k = 0; k < 10 && !(mem_we && mem_addr == AW'(BASE)); k++) @(negedge clk);
        fire(0, 0); step_release();
        chk("R10 drain continues", int'(stall), 1);
        drain();
        chk("R10 serviced twice", int'(ram[BASE]), 16'h0102);

        done = 1;
        report();
        $finish;
    end

endmodule